// File: doc/BRIEF.md
# Lockstep Mesh Router Node

This block is one router in a two-dimensional mesh of processing nodes. It has five byte-wide links: one to the local core and one each to the west, north, east and south neighbours. A packet is two bytes long. The first byte is the destination, with the column in the upper nibble and the row in the lower nibble. The second byte is the payload. Each link moves one packet per two-cycle frame: the destination goes in the first cycle and the payload in the second. Every node leaves reset on the same cycle. All routers therefore agree on which cycle is which without any framing signal. There is no handshake.

In each frame the router rebuilds the packets arriving on its five inputs. It keeps the one with the highest priority and discards the rest. It then chooses an output using x-first dimension-ordered routing and sends the packet out on that port during the next frame. A packet that is already at its destination leaves on the local port, which delivers it to the core. The node's own column and row come in on constant inputs, counted from 1.

Top module: `mesh_router_node`

## Requirements
- R1: While reset is high, and on the first cycle after reset, every output valid bit is 0. The first cycle after reset is the destination cycle of a frame, and frames then alternate strictly: destination cycle, then payload cycle.
- R2: Port indices are 0 local, 1 west, 2 north, 3 east and 4 south. Link p occupies data bits [8p+7:8p]. On output, a packet shows its destination byte during the destination cycle and its payload during the payload cycle, with the same single valid bit high in both cycles.
- R3: The destination byte holds x in bits [7:4] and y in bits [3:0], so x=4, y=5 is 69. An input valid bit marks a packet only when it is sampled in the destination cycle. A valid bit seen only in the payload cycle creates no packet.
- R4: If the destination x is greater than the node's own x, the packet goes east. If it is smaller, the packet goes west. The x test is applied before any y test.
- R5: When x matches, a greater destination y goes south and a smaller one goes north.
- R6: When both x and y match, the packet leaves on the local port.
- R7: When several packets arrive in the same frame, only the one on the lowest-numbered port is forwarded (local, then west, north, east, south). All others are dropped, so at most one output valid bit is high at any time.
- R8: A packet accepted in frame n leaves in frame n+1. Its destination appears two cycles after its destination cycle on input. No output is valid unless a packet was valid on some input in the destination cycle two cycles earlier.
- R9: An output port whose valid bit is low drives all-zero data. An empty frame produces nothing in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the frame phase |
| own_x | input | 4 | Node column, constant, counted from 1 |
| own_y | input | 4 | Node row, constant, counted from 1 |
| in_vld | input | 5 | Per-port input valid, one bit per link |
| in_dat | input | 40 | Per-port input bytes, link p at [8p+7:8p] |
| out_vld | output | 5 | Per-port output valid, registered |
| out_dat | output | 40 | Per-port output bytes, registered |

## Verification
Single packets are sent from the local port to a node at (2,3) with destinations in each direction. These separate the x-first choice from the y choice, for example a target that differs in both x and y must still go east. Contention frames with two and with three valid inputs separate the priority order from plain arrival order. A payload-cycle-only valid bit and empty frames show that the phase gates packet creation. Back-to-back frames from changing ports are compared on every clock against a behavioural frame model, which exposes errors in latency and in the destination/payload order.

// File: rtl/mrn_pkg.sv
package mrn_pkg;
  localparam int NPORT = 5;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_WEST  = 3'd1,
    PORT_NORTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;
endpackage

// File: rtl/mrn_deser.sv
module mrn_deser #(
  parameter int LINK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_val,
  input  logic              lnk_vld,
  input  logic [LINK_W-1:0] lnk_dat,
  output logic              pkt_vld,
  output logic [LINK_W-1:0] pkt_dst,
  output logic [LINK_W-1:0] pkt_val
);
  logic              dst_vld_q;
  logic [LINK_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_vld_q <= 1'b0;
      dst_q     <= '0;
    end else if (!phase_val) begin
      dst_vld_q <= lnk_vld;
      dst_q     <= lnk_dat;
    end
  end

  // packet is complete during the payload cycle
  always_comb begin
    pkt_vld = phase_val && dst_vld_q;
    pkt_dst = dst_q;
    pkt_val = lnk_dat;
  end
endmodule

// File: rtl/mrn_arbiter.sv
module mrn_arbiter
  import mrn_pkg::*;
#(
  parameter int COORD_W = 4,
  localparam int LINK_W = 2 * COORD_W
) (
  input  logic [NPORT-1:0]        req,
  input  logic [NPORT*LINK_W-1:0] dst_bus,
  input  logic [NPORT*LINK_W-1:0] val_bus,
  input  logic [COORD_W-1:0]      own_x,
  input  logic [COORD_W-1:0]      own_y,
  output logic                    win_vld,
  output port_e                   win_dir,
  output logic [LINK_W-1:0]       win_dst,
  output logic [LINK_W-1:0]       win_val
);
  logic [COORD_W-1:0] tx, ty;

  always_comb begin
    win_vld = 1'b0;
    win_dst = '0;
    win_val = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (req[p]) begin
        win_vld = 1'b1;
        win_dst = dst_bus[p*LINK_W +: LINK_W];
        win_val = val_bus[p*LINK_W +: LINK_W];
      end
    end
    tx = win_dst[LINK_W-1:COORD_W];
    ty = win_dst[COORD_W-1:0];
    if (tx > own_x)      win_dir = PORT_EAST;
    else if (tx < own_x) win_dir = PORT_WEST;
    else if (ty > own_y) win_dir = PORT_SOUTH;
    else if (ty < own_y) win_dir = PORT_NORTH;
    else                 win_dir = PORT_LOCAL;
  end
endmodule

// File: rtl/mrn_ser.sv
module mrn_ser
  import mrn_pkg::*;
#(
  parameter int LINK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    phase_val,
  input  logic                    load,
  input  port_e                   dir,
  input  logic [LINK_W-1:0]       dst,
  input  logic [LINK_W-1:0]       val,
  output logic [NPORT-1:0]        out_vld,
  output logic [NPORT*LINK_W-1:0] out_dat
);
  logic              hold_act;
  port_e             hold_dir;
  logic [LINK_W-1:0] hold_val;
  logic [NPORT-1:0]        nxt_vld;
  logic [NPORT*LINK_W-1:0] nxt_dat;

  always_comb begin
    nxt_vld = '0;
    nxt_dat = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (phase_val && load && dir == port_e'(p)) begin
        nxt_vld[p] = 1'b1;
        nxt_dat[p*LINK_W +: LINK_W] = dst;
      end else if (!phase_val && hold_act && hold_dir == port_e'(p)) begin
        nxt_vld[p] = 1'b1;
        nxt_dat[p*LINK_W +: LINK_W] = hold_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= '0;
      out_dat  <= '0;
      hold_act <= 1'b0;
      hold_dir <= PORT_LOCAL;
      hold_val <= '0;
    end else begin
      out_vld <= nxt_vld;
      out_dat <= nxt_dat;
      if (phase_val) begin
        hold_act <= load;
        hold_dir <= dir;
        hold_val <= val;
      end else begin
        hold_act <= 1'b0;
      end
    end
  end

  assert_one_port_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_vld));

  // payload cycle keeps the port chosen in the destination cycle
  assert_frame_hold_R2: assert property (@(posedge clk) disable iff (rst)
    phase_val |-> out_vld == $past(out_vld));

  for (genvar g = 0; g < NPORT; g++) begin : g_idle
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
      !out_vld[g] |-> out_dat[g*LINK_W +: LINK_W] == '0);
  end
endmodule

// File: rtl/mesh_router_node.sv
module mesh_router_node
  import mrn_pkg::*;
#(
  parameter int COORD_W = 4,
  localparam int LINK_W = 2 * COORD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [COORD_W-1:0]      own_x,
  input  logic [COORD_W-1:0]      own_y,
  input  logic [NPORT-1:0]        in_vld,
  input  logic [NPORT*LINK_W-1:0] in_dat,
  output logic [NPORT-1:0]        out_vld,
  output logic [NPORT*LINK_W-1:0] out_dat
);
  logic phase_val;   // 0: destination cycle, 1: payload cycle
  logic [NPORT-1:0]        req;
  logic [NPORT*LINK_W-1:0] dst_bus, val_bus;
  logic                    win_vld;
  port_e                   win_dir;
  logic [LINK_W-1:0]       win_dst, win_val;

  always_ff @(posedge clk) begin
    if (rst) phase_val <= 1'b0;
    else     phase_val <= ~phase_val;
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_in
    mrn_deser #(.LINK_W(LINK_W)) deser_i (
      .clk      (clk),
      .rst      (rst),
      .phase_val(phase_val),
      .lnk_vld  (in_vld[g]),
      .lnk_dat  (in_dat[g*LINK_W +: LINK_W]),
      .pkt_vld  (req[g]),
      .pkt_dst  (dst_bus[g*LINK_W +: LINK_W]),
      .pkt_val  (val_bus[g*LINK_W +: LINK_W])
    );
  end

  mrn_arbiter #(.COORD_W(COORD_W)) arb_i (
    .req    (req),
    .dst_bus(dst_bus),
    .val_bus(val_bus),
    .own_x  (own_x),
    .own_y  (own_y),
    .win_vld(win_vld),
    .win_dir(win_dir),
    .win_dst(win_dst),
    .win_val(win_val)
  );

  mrn_ser #(.LINK_W(LINK_W)) ser_i (
    .clk      (clk),
    .rst      (rst),
    .phase_val(phase_val),
    .load     (win_vld),
    .dir      (win_dir),
    .dst      (win_dst),
    .val      (win_val),
    .out_vld  (out_vld),
    .out_dat  (out_dat)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && !phase_val));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    (!phase_val && out_vld != '0) |-> $past(in_vld != '0, 2));
endmodule

// File: tb/mesh_router_node_tb_top.sv
module mesh_router_node_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  own_x = 4'd2;
  logic [3:0]  own_y = 4'd3;
  logic [4:0]  in_vld = '0;
  logic [39:0] in_dat = '0;
  logic [4:0]  out_vld;
  logic [39:0] out_dat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mesh_router_node dut_i (
    .clk(clk), .rst(rst), .own_x(own_x), .own_y(own_y),
    .in_vld(in_vld), .in_dat(in_dat), .out_vld(out_vld), .out_dat(out_dat)
  );

  // behavioural frame model
  int          m_ph;
  logic [4:0]  cap_vld;
  logic [39:0] cap_dat;
  bit          pend;
  int          pend_port;
  logic [7:0]  pend_val;
  logic [4:0]  exp_vld;
  logic [39:0] exp_dat;

  function automatic int route(logic [7:0] d);
    if (d[7:4] > own_x) return 3;
    if (d[7:4] < own_x) return 1;
    if (d[3:0] > own_y) return 4;
    if (d[3:0] < own_y) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; pend = 0; exp_vld = '0; exp_dat = '0;
    end else if (m_ph == 0) begin
      cap_vld = in_vld; cap_dat = in_dat;
      exp_vld = '0; exp_dat = '0;
      if (pend) begin
        exp_vld[pend_port] = 1'b1;
        exp_dat[pend_port*8 +: 8] = pend_val;
      end
      pend = 0;
      m_ph = 1;
    end else begin
      int w;
      w = -1;
      for (int p = 4; p >= 0; p--) if (cap_vld[p]) w = p;
      exp_vld = '0; exp_dat = '0;
      if (w >= 0) begin
        pend_port = route(cap_dat[w*8 +: 8]);
        pend_val  = in_dat[w*8 +: 8];
        pend = 1;
        exp_vld[pend_port] = 1'b1;
        exp_dat[pend_port*8 +: 8] = cap_dat[w*8 +: 8];
      end
      m_ph = 0;
    end
  end

  // every-cycle comparison against the model (R2, R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (out_vld !== exp_vld || out_dat !== exp_dat) begin
        n_bad++;
        $display("FAIL R8 model: vld=%b dat=%h expected vld=%b dat=%h",
                 out_vld, out_dat, exp_vld, exp_dat);
      end
    end
  end

  task automatic send(input logic [4:0] m, input logic [39:0] a, input logic [39:0] v);
    in_vld = m; in_dat = a;
    @(negedge clk);
    in_vld = m; in_dat = v;
    @(negedge clk);
  endtask

  task automatic send1(input int p, input logic [7:0] a, input logic [7:0] v);
    logic [39:0] aa, vv;
    aa = '0; vv = '0;
    aa[p*8 +: 8] = a; vv[p*8 +: 8] = v;
    send(5'b1 << p, aa, vv);
  endtask

  // checks the frame following a send; consumes one idle frame
  task automatic expect_out(input int port, input logic [7:0] a, input logic [7:0] v,
                            input string tag);
    logic [4:0] ev;
    ev = (port < 0) ? 5'b0 : (5'b1 << port);
    in_vld = '0; in_dat = '0;
    n_chk++;
    if (out_vld !== ev || (port >= 0 && out_dat[port*8 +: 8] !== a)) begin
      n_bad++;
      $display("FAIL %s dst cycle: vld=%b dat=%h expected vld=%b byte=%h",
               tag, out_vld, out_dat, ev, a);
    end
    @(negedge clk);
    n_chk++;
    if (out_vld !== ev || (port >= 0 && out_dat[port*8 +: 8] !== v)) begin
      n_bad++;
      $display("FAIL %s payload cycle: vld=%b dat=%h expected vld=%b byte=%h",
               tag, out_vld, out_dat, ev, v);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_vld !== 5'b0) begin
      n_bad++;
      $display("FAIL R1 reset: vld=%b expected 00000", out_vld);
    end
    rst = 1'b0;
    send(5'b0, '0, '0);
    expect_out(-1, 8'h00, 8'h00, "R1 idle after reset");
    send1(0, 8'h53, 8'hA1);  expect_out(3, 8'h53, 8'hA1, "R4 east");
    send1(0, 8'h13, 8'hA2);  expect_out(1, 8'h13, 8'hA2, "R4 west");
    send1(0, 8'h45, 8'hA3);  expect_out(3, 8'h45, 8'hA3, "R4 x first");
    send1(2, 8'h27, 8'hA4);  expect_out(4, 8'h27, 8'hA4, "R5 south");
    send1(4, 8'h21, 8'hA5);  expect_out(2, 8'h21, 8'hA5, "R5 north");
    send1(3, 8'h23, 8'hA6);  expect_out(0, 8'h23, 8'hA6, "R6 local");
    // R3: x=4,y=5 is byte 69 on the east port
    send1(0, 8'd69, 8'h11);  expect_out(3, 8'd69, 8'h11, "R3 encoding");
    // R3: valid only in payload cycle is ignored
    in_vld = '0; in_dat = 40'h23;
    @(negedge clk);
    in_vld = 5'b00001; in_dat = 40'h77;
    @(negedge clk);
    expect_out(-1, 8'h00, 8'h00, "R3 payload-only valid");
    // R7: west, north, east compete; west wins
    send(5'b01110, {8'h0, 8'h21, 8'h27, 8'h13, 8'h0}, {8'h0, 8'hC3, 8'hC2, 8'hC1, 8'h0});
    expect_out(1, 8'h13, 8'hC1, "R7 west wins");
    // R7: local and south compete; local wins
    send(5'b10001, {8'h53, 8'h0, 8'h0, 8'h0, 8'h27}, {8'hD4, 8'h0, 8'h0, 8'h0, 8'hD0});
    expect_out(4, 8'h27, 8'hD0, "R7 local wins");
    // R9: empty frame
    send(5'b0, 40'hFFFF_FFFF_FF, 40'hFFFF_FFFF_FF);
    expect_out(-1, 8'h00, 8'h00, "R9 empty frame");
    // R8: back-to-back frames, checked by the model every cycle
    send1(1, 8'h23, 8'h01);
    send1(2, 8'h53, 8'h02);
    send1(3, 8'h21, 8'h03);
    send(5'b11111, {8'h13, 8'h27, 8'h45, 8'h21, 8'h53}, {8'h5, 8'h4, 8'h3, 8'h2, 8'h1});
    expect_out(3, 8'h53, 8'h01, "R8 after burst");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule